// File: doc/BRIEF.md
# Infrared Pulse Encoder and Decoder

This block sits between a UART and an infrared transceiver. In infrared mode it turns each logic-zero bit of the NRZ transmit stream into one short high pulse. The pulse sits at the centre of the bit cell. Its width is either three or four sixteenths of a bit, chosen by a configuration input. Logic-one bits leave the infrared line dark (low).

On the receive side the raw infrared line passes through a synchronizer. The decoder then stretches every detected pulse back into a full-width zero on the recovered NRZ output. An optional inversion lets the decoder accept transceivers whose receive output idles high and pulses low.

All bit timing comes from a single-cycle 16x oversampling tick, which the UART's baud generator supplies. Infrared mode is off after reset. While it is off, both directions pass the NRZ levels through without change.

Top module: `ir_pulse_codec`

## Requirements
- R1: While reset is high, and after it is released with infrared mode off, `ir_tx` and `rx_nrz` are both 1.
- R2: With `ir_en` = 0, `ir_tx` equals the value `tx_nrz` had one clock earlier.
- R3: With `ir_en` = 0, `rx_nrz` follows `ir_rx_raw` three clocks later (two synchronizer flops plus the output register), and `rx_invert` has no effect.
- R4: With `ir_en` = 1, a bit cell whose latched value is 1 keeps `ir_tx` at 0 for all sixteen slots.
- R5: With `ir_en` = 1 and `pulse_wide` = 0, a zero bit drives `ir_tx` high in slots 7, 8 and 9 and low in every other slot. Each slot's level appears one clock after the tick that enters that slot.
- R6: With `ir_en` = 1 and `pulse_wide` = 1, a zero bit drives `ir_tx` high in slots 6, 7, 8 and 9 and low elsewhere.
- R7: `tx_nrz` is latched only on the tick that enters slot 0. A change of `tx_nrz` in the middle of a bit cell does not change that cell's pulse.
- R8: With `ir_en` = 1 and `rx_invert` = 0, a high level on `ir_rx_raw` is a pulse. `rx_nrz` goes to 0 three clocks after the line rises.
- R9: After the synchronized pulse ends, `rx_nrz` stays 0 through 15 ticks and returns to 1 on the clock that takes the 16th tick. A new pulse before then restarts the count.
- R10: With `ir_en` = 1 and `rx_invert` = 1, a low level on `ir_rx_raw` is the pulse and a steady high level is idle.
- R11: Reset puts the slot counter at slot 15, so the first tick after reset begins a bit cell at slot 0. The counter advances only on ticks and wraps from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-clock strobe at 16 times the baud rate |
| ir_en | input | 1 | 1 selects infrared coding, 0 selects NRZ pass-through |
| pulse_wide | input | 1 | 0 selects a 3/16-bit pulse, 1 selects a 4/16-bit pulse |
| rx_invert | input | 1 | 1 treats a low receive level as a pulse |
| tx_nrz | input | 1 | NRZ transmit bit from the UART |
| ir_rx_raw | input | 1 | Asynchronous receive line from the transceiver |
| ir_tx | output | 1 | Infrared transmit line (registered) |
| rx_nrz | output | 1 | Recovered NRZ receive bit (registered) |

## Verification
The bench checks every slot of each transmitted bit. A pulse that is off by one slot, or that uses the wrong width for the select, fails at a slot edge. So does any light during a one bit. It flips `tx_nrz` in the middle of a cell, which catches a design that samples the bit level continuously instead of latching it at the cell start. On receive it counts ticks exactly around the 16-tick hold, so a design that returns to 1 one tick early or late fails, and so does one that does not restart on a second pulse. Both polarities are exercised, along with pass-through with `rx_invert` set, which catches inversion leaking into the disabled path.

// File: rtl/ir_codec_pkg.sv
package ir_codec_pkg;

  typedef enum logic {
    PW_3_16 = 1'b0,
    PW_4_16 = 1'b1
  } pw_sel_e;

  // Pulse window centred on the middle of the cell; it ends one slot past the middle.
  function automatic logic slot_in_pulse(input int unsigned slot,
                                         input int unsigned ovs,
                                         input pw_sel_e     width);
    int unsigned hi;
    int unsigned lo;
    hi = ovs / 2 + 1;
    lo = (width == PW_4_16) ? ovs / 2 - 2 : ovs / 2 - 1;
    return (slot >= lo) && (slot <= hi);
  endfunction

endpackage

// File: rtl/ir_slot_timer.sv
module ir_slot_timer #(
  parameter int OVS = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick_i,
  output logic [$clog2(OVS)-1:0]  slot_o,
  output logic                    bit_start_o
);
  localparam int SW = $clog2(OVS);
  localparam logic [SW-1:0] LAST = SW'(OVS - 1);

  logic [SW-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= LAST;
    end else if (tick_i) begin
      slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
    end
  end

  assign slot_o      = slot_q;
  assign bit_start_o = tick_i && (slot_q == LAST);

  // R11: wrap to slot 0 after the last slot
  a_r11_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick_i && slot_q == LAST) |=> (slot_q == '0));
  // R11: no movement without a tick
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(slot_q));

endmodule

// File: rtl/ir_tx_encoder.sv
module ir_tx_encoder
  import ir_codec_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ir_en_i,
  input  pw_sel_e                 width_i,
  input  logic                    tx_nrz_i,
  input  logic                    bit_start_i,
  input  logic [$clog2(OVS)-1:0]  slot_i,
  output logic                    ir_tx_o
);
  logic bit_q;
  logic tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= 1'b1;
      tx_q  <= 1'b1;
    end else begin
      if (bit_start_i) bit_q <= tx_nrz_i;
      if (ir_en_i) tx_q <= !bit_q && slot_in_pulse(32'(slot_i), OVS, width_i);
      else         tx_q <= tx_nrz_i;
    end
  end

  assign ir_tx_o = tx_q;

  // R2: pass-through when infrared mode is off
  a_r2_passthru: assert property (@(posedge clk) disable iff (rst)
    !ir_en_i |=> (ir_tx_o == $past(tx_nrz_i)));
  // R4: a one bit emits no light
  a_r4_one_dark: assert property (@(posedge clk) disable iff (rst)
    (ir_en_i && bit_q) |=> !ir_tx_o);
  // R5: narrow pulse does not start early
  a_r5_narrow_start: assert property (@(posedge clk) disable iff (rst)
    (ir_en_i && !bit_q && width_i == PW_3_16 && 32'(slot_i) == OVS / 2 - 2) |=> !ir_tx_o);
  // R6: the centre slot of a zero bit is always lit
  a_r6_centre_lit: assert property (@(posedge clk) disable iff (rst)
    (ir_en_i && !bit_q && 32'(slot_i) == OVS / 2) |=> ir_tx_o);

endmodule

// File: rtl/ir_rx_decoder.sv
module ir_rx_decoder #(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ir_en_i,
  input  logic invert_i,
  input  logic tick_i,
  input  logic rx_raw_i,
  output logic rx_nrz_o
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic                   pulse;
  logic [CW-1:0]          hold_q;
  logic                   rx_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_raw_i};
  end

  assign synced = sync_q[SYNC_STAGES-1];
  assign pulse  = invert_i ? !synced : synced;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q   <= 1'b1;
      hold_q <= '0;
    end else if (!ir_en_i) begin
      rx_q   <= synced;
      hold_q <= '0;
    end else if (pulse) begin
      rx_q   <= 1'b0;
      hold_q <= '0;
    end else if (!rx_q && tick_i) begin
      if (hold_q == LAST) begin
        rx_q   <= 1'b1;
        hold_q <= '0;
      end else begin
        hold_q <= hold_q + 1'b1;
      end
    end
  end

  assign rx_nrz_o = rx_q;

  // R3: disabled path copies the synchronized line
  a_r3_passthru: assert property (@(posedge clk) disable iff (rst)
    !ir_en_i |=> (rx_nrz_o == $past(synced)));
  // R8: a detected pulse forces a zero
  a_r8_pulse_low: assert property (@(posedge clk) disable iff (rst)
    (ir_en_i && pulse) |=> !rx_nrz_o);
  // R9: recovery to one only happens on a tick
  a_r9_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    (ir_en_i && !rx_q && !tick_i) |=> !rx_nrz_o);

endmodule

// File: rtl/ir_pulse_codec.sv
module ir_pulse_codec
  import ir_codec_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick16,
  input  logic ir_en,
  input  logic pulse_wide,
  input  logic rx_invert,
  input  logic tx_nrz,
  input  logic ir_rx_raw,
  output logic ir_tx,
  output logic rx_nrz
);
  localparam int SW = $clog2(OVS);

  logic [SW-1:0] slot;
  logic          bit_start;
  pw_sel_e       width_sel;

  assign width_sel = pw_sel_e'(pulse_wide);

  ir_slot_timer #(.OVS(OVS)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick16),
    .slot_o      (slot),
    .bit_start_o (bit_start)
  );

  ir_tx_encoder #(.OVS(OVS)) u_enc (
    .clk         (clk),
    .rst         (rst),
    .ir_en_i     (ir_en),
    .width_i     (width_sel),
    .tx_nrz_i    (tx_nrz),
    .bit_start_i (bit_start),
    .slot_i      (slot),
    .ir_tx_o     (ir_tx)
  );

  ir_rx_decoder #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .ir_en_i  (ir_en),
    .invert_i (rx_invert),
    .tick_i   (tick16),
    .rx_raw_i (ir_rx_raw),
    .rx_nrz_o (rx_nrz)
  );

  // R1: both lines idle high while in reset
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (ir_tx && rx_nrz));

endmodule

// File: tb/ir_pulse_codec_bench.sv
`timescale 1ns/1ps
module ir_pulse_codec_bench;
  logic clk = 1'b0;
  logic rst, tick16, ir_en, pulse_wide, rx_invert, tx_nrz, ir_rx_raw;
  logic ir_tx, rx_nrz;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    bit    sel;     // 0: ir_tx, 1: rx_nrz
    logic  val;
    string req;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  ir_pulse_codec u_ir_pulse_codec (
    .clk(clk), .rst(rst), .tick16(tick16), .ir_en(ir_en),
    .pulse_wide(pulse_wide), .rx_invert(rx_invert), .tx_nrz(tx_nrz),
    .ir_rx_raw(ir_rx_raw), .ir_tx(ir_tx), .rx_nrz(rx_nrz)
  );

  // Monitor: pops expectations pushed at a falling edge and compares them.
  always @(negedge clk) begin
    exp_t e;
    logic act;
    #1;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      act = e.sel ? rx_nrz : ir_tx;
      checks++;
      if (act !== e.val) begin
        errors++;
        $display("FAIL %s: %s actual=%b expected=%b at %0t",
                 e.req, e.sel ? "rx_nrz" : "ir_tx", act, e.val, $time);
      end
    end
  end

  task automatic expect_tx(logic v, string r);
    exp_q.push_back('{sel: 1'b0, val: v, req: r});
  endtask

  task automatic expect_rx(logic v, string r);
    exp_q.push_back('{sel: 1'b1, val: v, req: r});
  endtask

  // One bit cell: 16 ticks, four clocks apart, with each slot's level checked.
  task automatic send_bit(logic b, logic wide, bit flip_mid, string r);
    int lo;
    logic exp_v;
    lo = wide ? 6 : 7;
    tx_nrz = b;
    pulse_wide = wide;
    for (int j = 0; j < 16; j++) begin
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
      if (flip_mid && j == 4) tx_nrz = ~b;
      @(negedge clk);
      exp_v = (b == 1'b0) && (j >= lo) && (j <= 9);
      expect_tx(exp_v, r);
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  // n ticks with rx_nrz sampled right after each; final one expected high if last_high.
  task automatic rx_ticks(int n, bit last_high, string r);
    for (int k = 1; k <= n; k++) begin
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
      expect_rx((last_high && k == n) ? 1'b1 : 1'b0, r);
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  // Short active pulse on the raw line, then idle long enough to clear the synchronizer.
  task automatic rx_pulse(logic active);
    ir_rx_raw = active;
    repeat (2) @(negedge clk);
    ir_rx_raw = ~active;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tick16 = 1'b0; ir_en = 1'b0; pulse_wide = 1'b0;
    rx_invert = 1'b0; tx_nrz = 1'b1; ir_rx_raw = 1'b1;
    repeat (4) @(negedge clk);
    expect_tx(1'b1, "R1");
    expect_rx(1'b1, "R1");
    rst = 1'b0;
    @(negedge clk);
    expect_tx(1'b1, "R1");
    expect_rx(1'b1, "R1");

    // R2: transmit pass-through, one clock of latency
    tx_nrz = 1'b0;
    @(negedge clk); expect_tx(1'b0, "R2");
    tx_nrz = 1'b1;
    @(negedge clk); expect_tx(1'b1, "R2");

    // R3: receive pass-through, three clocks, inversion ignored
    rx_invert = 1'b1;
    ir_rx_raw = 1'b0;
    repeat (2) @(negedge clk); expect_rx(1'b1, "R3");
    @(negedge clk);            expect_rx(1'b0, "R3");
    ir_rx_raw = 1'b1;
    repeat (3) @(negedge clk); expect_rx(1'b1, "R3");
    rx_invert = 1'b0;

    // Enter infrared mode with the receive line dark
    ir_rx_raw = 1'b0;
    repeat (4) @(negedge clk);
    ir_en = 1'b1;
    @(negedge clk);

    // R4, R5, R6, R7, R11: transmit cells; the first tick after reset starts slot 0
    send_bit(1'b1, 1'b0, 1'b0, "R4");
    send_bit(1'b0, 1'b0, 1'b0, "R5,R11");
    send_bit(1'b0, 1'b1, 1'b0, "R6,R11");
    send_bit(1'b0, 1'b0, 1'b1, "R7");
    send_bit(1'b1, 1'b1, 1'b1, "R7");
    tx_nrz = 1'b1;
    expect_rx(1'b1, "R9");

    // R8: pulse latency
    ir_rx_raw = 1'b1;
    repeat (2) @(negedge clk); expect_rx(1'b1, "R8");
    @(negedge clk);            expect_rx(1'b0, "R8");
    ir_rx_raw = 1'b0;
    repeat (4) @(negedge clk);
    // R9: exactly 16 ticks of quiet
    rx_ticks(16, 1'b1, "R9");

    // R9: a second pulse restarts the hold count
    rx_pulse(1'b1);
    expect_rx(1'b0, "R8");
    rx_ticks(8, 1'b0, "R9");
    rx_pulse(1'b1);
    rx_ticks(16, 1'b1, "R9");

    // R10: inverted polarity
    rx_invert = 1'b1;
    repeat (3) @(negedge clk);
    expect_rx(1'b0, "R10");
    ir_rx_raw = 1'b1;
    repeat (4) @(negedge clk);
    rx_ticks(16, 1'b1, "R10");
    repeat (6) @(negedge clk);
    expect_rx(1'b1, "R10");
    rx_pulse(1'b0);
    expect_rx(1'b0, "R10");
    rx_ticks(16, 1'b1, "R10");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule